// File: doc/BRIEF.md
# Copy-on-Write Page Command Engine

This engine sits inside a memory controller and carries out page-level copy-on-write bookkeeping on behalf of software. Software loads a source page number, a destination page number and a command word into a small register window, and sets a go bit in the same command write. The engine then works through the destination page's metadata block over a metadata memory port and, when a physical copy is needed, moves whole data lines over a data memory port. Completion shows on a busy flag and a sticky done flag, both on status pins and in a readable status register.

Each page has one aligned metadata block: a major counter and one small counter per line. The top bit of every per-line counter is lent to the page's source pointer. Line i supplies pointer bit i. The remaining low bits hold the counter value, and a value of zero means the line is a hole whose contents still live in the source page. There are three commands. A logical copy turns every line of the destination into a hole that points at a given source. A physical copy fills every hole from the source page and cuts the link. A free wipes the metadata.

Top module: `cow_page_engine`

## Requirements
- R1: After reset, busy and done are 0, the command, source and destination registers read 0, and no memory request is raised.
- R2: Metadata block layout: bits [MAJOR_W-1:0] hold the major counter. Counter i occupies bits [MAJOR_W+i*CNT_W +: CNT_W]. Its top bit is pointer bit i, and its low CNT_W-1 bits are the value. Logical copy (command code 2'b01) reads the destination block once and writes it back once. The write keeps the major counter and sets counter i to {src[i], zero value}.
- R3: Physical copy (command code 2'b10) takes the source page from the pointer bits in the destination block, not from the source register. For every line whose value is zero, and only those, it reads that line from the source page and then writes it to the same line of the destination. It visits lines in ascending order and never has both memory ports requesting at once.
- R4: After all holes are filled, a physical copy writes the destination block exactly once. The major counter is kept, filled lines get value 1, other values are unchanged, and every pointer bit is 0.
- R5: Free (command code 2'b11) writes an all-zero block to the destination page without reading it, and moves no data.
- R6: A command write with go set while busy is ignored. It neither starts a command nor changes the stored command code.
- R7: Busy rises on the cycle after an accepted go and falls when the final metadata write is acknowledged. At that point done becomes 1 and stays 1 until the next accepted go clears it. Busy and done are never both 1.
- R8: A go with command code 2'b00 is ignored. Busy stays 0, done keeps its value, and there is no memory traffic.
- R9: Register map: offset 0 is the command word (bits [1:0] code, bit 2 go), offset 1 is the source page, offset 2 is the destination page, and offset 3 is status (bit 0 busy, bit 1 done).
- R10: Each memory request holds its request, direction and address steady until acknowledged.
- R11: A physical copy of a page with no holes moves no data lines and still clears the pointer in one metadata write.
- R12: Each destination line write carries the data returned by the source read immediately before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational from reg_addr) |
| meta_req | output | 1 | Metadata request |
| meta_we | output | 1 | Metadata request is a write |
| meta_addr | output | LINES | Page number of the metadata block |
| meta_wdata | output | MAJOR_W+LINES*CNT_W | Metadata block to write |
| meta_rdata | input | MAJOR_W+LINES*CNT_W | Metadata block returned with the acknowledge |
| meta_ack | input | 1 | Metadata request acknowledge |
| data_req | output | 1 | Data line request |
| data_we | output | 1 | Data request is a write |
| data_addr | output | LINES+clog2(LINES) | {page, line} of the data line |
| data_wdata | output | DATA_W | Line data to write |
| data_rdata | input | DATA_W | Line data returned with the acknowledge |
| data_ack | input | 1 | Data request acknowledge |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Sticky completion flag |

## Verification
On every cycle, the embedded properties guard the port handshake: requests stay stable until acknowledged, the two ports never request together, each line write directly follows its source read, a free issues no metadata read, and busy and done stay exclusive. Only the bench scenarios can show the data-dependent results. These include which lines were copied and in what order, the exact metadata block written back for every one of the 256 hole patterns of an eight-line page, logical copy for all 256 source values, and the ignoring of a go issued mid-command or with code 2'b00.

// File: rtl/cow_pkg.sv
package cow_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'b00,
        CMD_LCOPY = 2'b01,
        CMD_PCOPY = 2'b10,
        CMD_FREE  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MRD,
        ST_SCAN,
        ST_DRD,
        ST_DWR,
        ST_MWR
    } state_e;

    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_SRC  = 2'd1;
    localparam logic [1:0] OFS_DST  = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    localparam int GO_BIT = 2;

endpackage

// File: rtl/cow_meta_codec.sv
module cow_meta_codec #(
    parameter int LINES   = 64,
    parameter int CNT_W   = 7,
    parameter int MAJOR_W = 64,
    localparam int META_W = MAJOR_W + LINES * CNT_W
) (
    input  logic [META_W-1:0]             blk_i,
    output logic [MAJOR_W-1:0]            major_o,
    output logic [LINES-1:0][CNT_W-1:0]   cnt_o,
    input  logic [MAJOR_W-1:0]            major_i,
    input  logic [LINES-1:0][CNT_W-1:0]   cnt_i,
    output logic [META_W-1:0]             blk_o
);

    assign major_o               = blk_i[MAJOR_W-1:0];
    assign blk_o[MAJOR_W-1:0]    = major_i;

    for (genvar g = 0; g < LINES; g++) begin : g_field
        assign cnt_o[g]                                  = blk_i[MAJOR_W + g*CNT_W +: CNT_W];
        assign blk_o[MAJOR_W + g*CNT_W +: CNT_W]         = cnt_i[g];
    end

endmodule

// File: rtl/cow_hole_finder.sv
module cow_hole_finder #(
    parameter int LINES = 64,
    localparam int LINE_AW = $clog2(LINES)
) (
    input  logic [LINES-1:0]   mask_i,
    output logic               any_o,
    output logic [LINE_AW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = LINE_AW'(i);
        end
    end

    assign any_o = |mask_i;

endmodule

// File: rtl/cow_regs.sv
module cow_regs
    import cow_pkg::*;
#(
    parameter int REG_W = 64,
    parameter int PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             finish,
    output logic             start,
    output cmd_e             start_cmd,
    output logic [PTR_W-1:0] src_o,
    output logic [PTR_W-1:0] dst_o,
    output logic             done
);

    cmd_e             cmd_q;
    logic [PTR_W-1:0] src_q;
    logic [PTR_W-1:0] dst_q;
    logic             ctrl_wr;

    assign ctrl_wr   = reg_wr && (reg_addr == OFS_CTRL) && !busy;
    assign start_cmd = cmd_e'(reg_wdata[1:0]);
    assign start     = ctrl_wr && reg_wdata[GO_BIT] && (start_cmd != CMD_NONE);
    assign src_o     = src_q;
    assign dst_o     = dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_NONE;
            src_q <= '0;
            dst_q <= '0;
            done  <= 1'b0;
        end else begin
            if (ctrl_wr) cmd_q <= start_cmd;
            if (reg_wr && reg_addr == OFS_SRC) src_q <= reg_wdata[PTR_W-1:0];
            if (reg_wr && reg_addr == OFS_DST) dst_q <= reg_wdata[PTR_W-1:0];
            if (start)       done <= 1'b0;
            else if (finish) done <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = REG_W'(cmd_q);
            OFS_SRC:  reg_rdata = REG_W'(src_q);
            OFS_DST:  reg_rdata = REG_W'(dst_q);
            default:  reg_rdata = REG_W'({done, busy});
        endcase
    end

    // R6: a command write during a running command leaves the stored code alone
    assert_busy_go_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFS_CTRL && busy) |=> $stable(cmd_q));

    // R7: an accepted go clears done on the following cycle
    assert_done_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);

endmodule

// File: rtl/cow_seq.sv
module cow_seq
    import cow_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int CNT_W   = 7,
    parameter int MAJOR_W = 64,
    parameter int DATA_W  = 512,
    localparam int PTR_W   = LINES,
    localparam int LINE_AW = $clog2(LINES),
    localparam int VAL_W   = CNT_W - 1,
    localparam int META_W  = MAJOR_W + LINES * CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  cmd_e                     cmd,
    input  logic [PTR_W-1:0]         src,
    input  logic [PTR_W-1:0]         dst,
    output logic                     busy,
    output logic                     finish,
    output logic                     meta_req,
    output logic                     meta_we,
    output logic [PTR_W-1:0]         meta_addr,
    output logic [META_W-1:0]        meta_wdata,
    input  logic [META_W-1:0]        meta_rdata,
    input  logic                     meta_ack,
    output logic                     data_req,
    output logic                     data_we,
    output logic [PTR_W+LINE_AW-1:0] data_addr,
    output logic [DATA_W-1:0]        data_wdata,
    input  logic [DATA_W-1:0]        data_rdata,
    input  logic                     data_ack
);

    state_e                         st;
    cmd_e                           cur;
    logic [PTR_W-1:0]               src_q, dst_q, ptr_q;
    logic [MAJOR_W-1:0]             maj_q;
    logic [LINES-1:0][CNT_W-1:0]    cnt_q;
    logic [LINE_AW-1:0]             line_q;
    logic [DATA_W-1:0]              buf_q;

    logic [MAJOR_W-1:0]             rd_major;
    logic [LINES-1:0][CNT_W-1:0]    rd_cnt;
    logic [PTR_W-1:0]               rd_ptr;
    logic [LINES-1:0]               holes;
    logic                           any_hole;
    logic [LINE_AW-1:0]             hole_idx;

    cow_meta_codec #(.LINES(LINES), .CNT_W(CNT_W), .MAJOR_W(MAJOR_W)) u_codec (
        .blk_i   (meta_rdata),
        .major_o (rd_major),
        .cnt_o   (rd_cnt),
        .major_i (maj_q),
        .cnt_i   (cnt_q),
        .blk_o   (meta_wdata)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign rd_ptr[g] = rd_cnt[g][CNT_W-1];
        assign holes[g]  = (cnt_q[g][VAL_W-1:0] == '0);
    end

    cow_hole_finder #(.LINES(LINES)) u_finder (
        .mask_i (holes),
        .any_o  (any_hole),
        .idx_o  (hole_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur    <= CMD_NONE;
            src_q  <= '0;
            dst_q  <= '0;
            ptr_q  <= '0;
            maj_q  <= '0;
            cnt_q  <= '0;
            line_q <= '0;
            buf_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    cur   <= cmd;
                    src_q <= src;
                    dst_q <= dst;
                    if (cmd == CMD_FREE) begin
                        maj_q <= '0;
                        cnt_q <= '0;
                        st    <= ST_MWR;
                    end else begin
                        st    <= ST_MRD;
                    end
                end
                ST_MRD: if (meta_ack) begin
                    maj_q <= rd_major;
                    if (cur == CMD_LCOPY) begin
                        for (int i = 0; i < LINES; i++)
                            cnt_q[i] <= {src_q[i], {VAL_W{1'b0}}};
                        st <= ST_MWR;
                    end else begin
                        cnt_q <= rd_cnt;
                        ptr_q <= rd_ptr;
                        st    <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (any_hole) begin
                        line_q <= hole_idx;
                        st     <= ST_DRD;
                    end else begin
                        for (int i = 0; i < LINES; i++)
                            cnt_q[i][CNT_W-1] <= 1'b0;
                        st <= ST_MWR;
                    end
                end
                ST_DRD: if (data_ack) begin
                    buf_q <= data_rdata;
                    st    <= ST_DWR;
                end
                ST_DWR: if (data_ack) begin
                    cnt_q[line_q][VAL_W-1:0] <= VAL_W'(1);
                    st <= ST_SCAN;
                end
                ST_MWR: if (meta_ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign finish     = (st == ST_MWR) && meta_ack;
    assign meta_req   = (st == ST_MRD) || (st == ST_MWR);
    assign meta_we    = (st == ST_MWR);
    assign meta_addr  = dst_q;
    assign data_req   = (st == ST_DRD) || (st == ST_DWR);
    assign data_we    = (st == ST_DWR);
    assign data_addr  = (st == ST_DWR) ? {dst_q, line_q} : {ptr_q, line_q};
    assign data_wdata = buf_q;

    // R10: requests stay put until acknowledged
    assert_meta_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (meta_req && !meta_ack) |=> (meta_req && $stable(meta_we) && $stable(meta_addr)));
    assert_data_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (data_req && !data_ack) |=> (data_req && $stable(data_we) && $stable(data_addr)));

    // R3: the two memory ports are never used together
    assert_ports_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(meta_req && data_req));

    // R12: a line write begins only right after an acknowledged line read
    assert_write_after_read_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(data_req && data_we) |-> $past(data_ack && data_req && !data_we));

    // R5: a free never reads metadata
    assert_free_no_read_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cur == CMD_FREE) |-> !(meta_req && !meta_we) && !data_req);

endmodule

// File: rtl/cow_page_engine.sv
module cow_page_engine
    import cow_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int CNT_W   = 7,
    parameter int MAJOR_W = 64,
    parameter int DATA_W  = 512,
    parameter int REG_W   = 64,
    localparam int PTR_W   = LINES,
    localparam int LINE_AW = $clog2(LINES),
    localparam int META_W  = MAJOR_W + LINES * CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     meta_req,
    output logic                     meta_we,
    output logic [PTR_W-1:0]         meta_addr,
    output logic [META_W-1:0]        meta_wdata,
    input  logic [META_W-1:0]        meta_rdata,
    input  logic                     meta_ack,
    output logic                     data_req,
    output logic                     data_we,
    output logic [PTR_W+LINE_AW-1:0] data_addr,
    output logic [DATA_W-1:0]        data_wdata,
    input  logic [DATA_W-1:0]        data_rdata,
    input  logic                     data_ack,
    output logic                     busy,
    output logic                     done
);

    logic             start, finish;
    cmd_e             start_cmd;
    logic [PTR_W-1:0] src_pg, dst_pg;

    cow_regs #(.REG_W(REG_W), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .finish    (finish),
        .start     (start),
        .start_cmd (start_cmd),
        .src_o     (src_pg),
        .dst_o     (dst_pg),
        .done      (done)
    );

    cow_seq #(.LINES(LINES), .CNT_W(CNT_W), .MAJOR_W(MAJOR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd        (start_cmd),
        .src        (src_pg),
        .dst        (dst_pg),
        .busy       (busy),
        .finish     (finish),
        .meta_req   (meta_req),
        .meta_we    (meta_we),
        .meta_addr  (meta_addr),
        .meta_wdata (meta_wdata),
        .meta_rdata (meta_rdata),
        .meta_ack   (meta_ack),
        .data_req   (data_req),
        .data_we    (data_we),
        .data_addr  (data_addr),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata),
        .data_ack   (data_ack)
    );

    // R1: an idle engine raises no memory request
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!meta_req && !data_req));

    // R7: busy and done are exclusive
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: tb/cow_page_engine_bench.sv
`timescale 1ns/1ps
module cow_page_engine_bench;

    localparam int LINES = 8, CNT_W = 7, MAJOR_W = 16, DATA_W = 32, REG_W = 64;
    localparam int META_W = MAJOR_W + LINES * CNT_W;

    logic clk = 0, rst = 1;
    always #10 clk = ~clk;

    logic              reg_wr = 0;
    logic [1:0]        reg_addr = 0;
    logic [REG_W-1:0]  reg_wdata = 0;
    logic [REG_W-1:0]  reg_rdata;
    logic              meta_req, meta_we, meta_ack = 0;
    logic [7:0]        meta_addr;
    logic [META_W-1:0] meta_wdata, meta_rdata = 0;
    logic              data_req, data_we, data_ack = 0;
    logic [10:0]       data_addr;
    logic [DATA_W-1:0] data_wdata, data_rdata = 0;
    logic              busy, done;

    cow_page_engine #(.LINES(LINES), .CNT_W(CNT_W), .MAJOR_W(MAJOR_W),
                      .DATA_W(DATA_W), .REG_W(REG_W)) u_cow_page_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .meta_req(meta_req), .meta_we(meta_we), .meta_addr(meta_addr),
        .meta_wdata(meta_wdata), .meta_rdata(meta_rdata), .meta_ack(meta_ack),
        .data_req(data_req), .data_we(data_we), .data_addr(data_addr),
        .data_wdata(data_wdata), .data_rdata(data_rdata), .data_ack(data_ack),
        .busy(busy), .done(done));

    logic [META_W-1:0] meta_mem [256];
    logic [DATA_W-1:0] data_mem [2048];

    int n_cmp = 0, n_bad = 0, cycles = 0;
    int m_rd, m_wr, d_rd, d_wr, ord_err, last_wr;
    logic [7:0] exp_src, last_rd_pg;
    logic [2:0] last_rd_ln;
    logic       run_over = 0;

    always @(posedge clk) begin
        cycles++;
        meta_ack <= 0;
        data_ack <= 0;
        if (meta_req && !meta_ack) begin
            meta_ack <= 1;
            if (meta_we) begin meta_mem[meta_addr] <= meta_wdata; m_wr++; end
            else begin meta_rdata <= meta_mem[meta_addr]; m_rd++; end
        end
        if (data_req && !data_ack) begin
            data_ack <= 1;
            if (data_we) begin
                data_mem[data_addr] <= data_wdata; d_wr++;
                if (data_addr[2:0] != last_rd_ln || last_rd_pg != exp_src) ord_err++;
                if (int'(data_addr[2:0]) <= last_wr) ord_err++;
                last_wr = int'(data_addr[2:0]);
            end else begin
                data_rdata <= data_mem[data_addr]; d_rd++;
                last_rd_pg = data_addr[10:3];
                last_rd_ln = data_addr[2:0];
            end
        end
    end

    task automatic clr_stats(input logic [7:0] src);
        m_rd = 0; m_wr = 0; d_rd = 0; d_wr = 0; ord_err = 0; last_wr = -1;
        exp_src = src;
    endtask

    task automatic check(input logic ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [63:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] s;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            reg_read(2'd3, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [META_W-1:0] pack(input logic [15:0] maj,
                                              input logic [LINES-1:0][6:0] c);
        logic [META_W-1:0] b;
        b[15:0] = maj;
        for (int i = 0; i < LINES; i++) b[16 + i*7 +: 7] = c[i];
        return b;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000 && !run_over) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] r;
        logic [LINES-1:0][6:0] c, ce;
        logic [7:0] p, d;
        logic ok;
        for (int i = 0; i < 256; i++) meta_mem[i] = '0;
        for (int i = 0; i < 2048; i++) data_mem[i] = '0;
        clr_stats(0);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        reg_read(2'd3, r); check(r == 0, "R1 status", r, 0);
        reg_read(2'd0, r); check(r == 0, "R1 ctrl", r, 0);
        reg_read(2'd1, r); check(r == 0, "R1 src", r, 0);
        check(!meta_req && !data_req && !busy && !done, "R1 idle pins",
              {meta_req, data_req, busy, done}, 0);

        // R3 R4 R11 R12: physical copy over every hole pattern
        for (int pat = 0; pat < 256; pat++) begin
            p = 8'(pat % 200 + 20);
            d = 8'd5;
            for (int i = 0; i < LINES; i++) begin
                c[i] = pat[i] ? {p[i], 6'd0} : {p[i], 6'(i + 2 + pat % 5)};
                ce[i] = pat[i] ? 7'd1 : {1'b0, 6'(i + 2 + pat % 5)};
                data_mem[{p, 3'(i)}] = 32'hA000_0000 | (32'(p) << 8) | 32'(i);
                data_mem[{d, 3'(i)}] = 32'hD000_0000 | (32'(pat) << 8) | 32'(i);
            end
            meta_mem[d] = pack({8'(pat), 8'h3C}, c);
            clr_stats(p);
            reg_write(2'd1, 64'd7);
            reg_write(2'd2, 64'(d));
            reg_write(2'd0, 64'h6);
            wait_idle();
            ok = 1;
            for (int i = 0; i < LINES; i++)
                if (data_mem[{d, 3'(i)}] != (pat[i] ? (32'hA000_0000 | (32'(p) << 8) | 32'(i))
                                                    : (32'hD000_0000 | (32'(pat) << 8) | 32'(i))))
                    ok = 0;
            check(ok, "R3 destination lines", 128'(pat), 128'(pat));
            check(meta_mem[d] == pack({8'(pat), 8'h3C}, ce), "R4 metadata written back",
                  128'(meta_mem[d]), 128'(pack({8'(pat), 8'h3C}, ce)));
            check(d_rd == $countones(8'(pat)) && d_wr == $countones(8'(pat)) && m_rd == 1 && m_wr == 1,
                  pat == 0 ? "R11 traffic no holes" : "R3 traffic",
                  {32'(d_rd), 32'(d_wr), 32'(m_rd), 32'(m_wr)}, 128'(pat));
            check(ord_err == 0, "R12 order and data source", 128'(ord_err), 0);
        end
        reg_read(2'd3, r); check(r == 64'h2, "R7 done after command", r, 64'h2);

        // R2: logical copy for every source value
        for (int s = 0; s < 256; s++) begin
            d = 8'd12;
            for (int i = 0; i < LINES; i++) begin
                c[i]  = 7'((i * 9 + s) % 128);
                ce[i] = {s[i], 6'd0};
            end
            meta_mem[d] = pack(16'hBEEF, c);
            clr_stats(0);
            reg_write(2'd1, 64'(s));
            reg_write(2'd2, 64'(d));
            reg_write(2'd0, 64'h5);
            wait_idle();
            check(meta_mem[d] == pack(16'hBEEF, ce), "R2 logical copy block",
                  128'(meta_mem[d]), 128'(pack(16'hBEEF, ce)));
            check(m_rd == 1 && m_wr == 1 && d_rd == 0 && d_wr == 0, "R2 traffic",
                  {32'(m_rd), 32'(m_wr), 32'(d_rd), 32'(d_wr)}, 128'h1_00000001_0_0);
        end

        // R5: free
        for (int i = 0; i < LINES; i++) c[i] = 7'(i + 40);
        meta_mem[9] = pack(16'h1234, c);
        clr_stats(0);
        reg_write(2'd2, 64'd9);
        reg_write(2'd0, 64'h7);
        wait_idle();
        check(meta_mem[9] == '0, "R5 free clears block", 128'(meta_mem[9]), 0);
        check(m_rd == 0 && m_wr == 1 && d_rd == 0 && d_wr == 0, "R5 free traffic",
              {32'(m_rd), 32'(m_wr), 32'(d_rd), 32'(d_wr)}, 128'h1_00000000_0);

        // R6 R7: go while busy is ignored
        p = 8'd50; d = 8'd6;
        for (int i = 0; i < LINES; i++) begin
            c[i] = {p[i], 6'd0};
            ce[i] = 7'd1;
            data_mem[{p, 3'(i)}] = 32'h5500 + 32'(i);
        end
        meta_mem[d] = pack(16'h0F0F, c);
        clr_stats(p);
        reg_write(2'd2, 64'(d));
        reg_write(2'd0, 64'h6);
        reg_read(2'd3, r); check(r == 64'h1, "R7 busy after go", r, 64'h1);
        repeat (3) @(negedge clk);
        reg_write(2'd0, 64'h7);
        reg_read(2'd3, r); check(r == 64'h1, "R6 still busy, done low", r, 64'h1);
        reg_read(2'd0, r); check(r == 64'h2, "R6 code unchanged", r, 64'h2);
        wait_idle();
        check(meta_mem[d] == pack(16'h0F0F, ce), "R6 ignored free", 128'(meta_mem[d]),
              128'(pack(16'h0F0F, ce)));
        check(d_wr == 8 && m_wr == 1, "R6 single command ran", 128'(d_wr), 128'd8);

        // R8 R9: code 00 go is ignored
        clr_stats(0);
        reg_write(2'd0, 64'h4);
        reg_read(2'd3, r); check(r == 64'h2, "R8 status unchanged", r, 64'h2);
        repeat (5) @(negedge clk);
        check(m_rd + m_wr + d_rd + d_wr == 0, "R8 no traffic", 128'(m_rd + m_wr + d_rd + d_wr), 0);
        reg_read(2'd0, r); check(r == 64'h0, "R9 code readback", r, 0);
        reg_write(2'd1, 64'h9A);
        reg_read(2'd1, r); check(r == 64'h9A, "R9 src readback", r, 64'h9A);

        run_over = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule